// File: doc/BRIEF.md
# Byte-Wide Host Read Port

This block is the slave side of a parallel host port. An external host fetches a 16-bit word that the local processor has placed in an output register. The host uses an 8-bit bus and makes two byte transfers: the low byte first, then the high byte. The host controls four lines: a chip select, a read/write line, one data strobe and a byte-select line. The block enables its bus pad driver only while a read strobe is valid. The enable comes combinationally from the raw pins, so output timing follows the host's edges.

The processor side loads a new word with a single-cycle write pulse, which marks the buffer as full. The host pins also pass through a synchronizer into the system clock domain. When the strobe that ends a high-byte read goes inactive, the block sets a buffer-empty flag and pulses an interrupt for one cycle. A two-bit control register, written over a small address/write-enable interface, can invert the active sense of the byte-select line and of the strobe.

Top module: `hrp_top`

## Requirements
- R1: After synchronous reset, `hbus_oe` is 0, `obuf_empty` is 1, `obuf_irq` is 0, the output word is 0, and both polarity bits are 0.
- R2: `hbus_oe` is 1 only when all three hold in the same cycle: `hst_sel_n` is 0, the strobe is at its active level, and `hst_rnw` is 1. The enable comes combinationally from the pins.
- R3: `hbus_oe` returns to 0 as soon as `hst_sel_n` goes high or the strobe goes inactive, whichever comes first, with no clock edge needed.
- R4: With byte-select at its low-byte level, `hbus_dout` shows word bits 7:0. At its high-byte level, `hbus_dout` shows bits 15:8. By default, `hst_bsel`=0 selects the low byte.
- R5: Writing control address 0 with bit 0 set inverts byte-select sense, so `hst_bsel`=0 selects the high byte.
- R6: Writing control address 0 with bit 1 set makes the strobe active high. When this bit is 0, the strobe is active low.
- R7: A high-byte read is a strobe during which chip select is low and `hst_rnw` is high. When its strobe goes inactive and the buffer is full, `obuf_empty` rises within 4 clock cycles and `obuf_irq` is high for exactly one cycle.
- R8: Low-byte reads, strobes with `hst_rnw` low, and strobes with chip select high leave `obuf_empty` unchanged and raise no interrupt.
- R9: A high-byte read while `obuf_empty` is already 1 keeps the flag at 1 and raises no interrupt.
- R10: `word_wr` loads `word_data` and clears `obuf_empty` on the next edge. If it coincides with the end of a high-byte read, the write wins: the flag stays 0 and no interrupt is raised.
- R11: A control write to any address other than 0 leaves the polarity bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write enable |
| ctl_addr | input | 2 | Control register address |
| ctl_wdata | input | 2 | Control data: bit 0 inverts byte-select, bit 1 inverts strobe |
| word_wr | input | 1 | Load pulse for the output word |
| word_data | input | 16 | New output word |
| hst_sel_n | input | 1 | Host chip select, active low |
| hst_rnw | input | 1 | Host read (1) / write (0) |
| hst_strb | input | 1 | Host data strobe, polarity programmable |
| hst_bsel | input | 1 | Host byte select, polarity programmable |
| hbus_dout | output | 8 | Byte presented to the bus pad |
| hbus_oe | output | 1 | Pad driver enable; bus is high impedance when 0 |
| obuf_empty | output | 1 | Output buffer empty flag |
| obuf_irq | output | 1 | One-cycle interrupt when the buffer empties |

## Verification
The assertions assume that the host holds chip select, read/write and byte-select steady for the whole time a strobe is active. They also assume that the polarity bits change only while chip select is high. The stimulus enforces both. Every host line changes on a falling clock edge, well away from strobe transitions. Each control write happens with chip select deasserted and the strobe parked. Only the collision test lines up a word load with the synchronized strobe end, and it computes that cycle from the two synchronizer stages and the one edge-detect register.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // bit 1: strobe sense, bit 0: byte-select sense
    typedef struct packed {
        logic inv_strb;
        logic inv_bsel;
    } hrp_ctl_t;

    localparam int CTL_W = $bits(hrp_ctl_t);

    typedef struct packed {
        logic sel_n;
        logic rnw;
        logic strb;
        logic bsel;
    } hrp_pins_t;

    localparam int PINS_W = $bits(hrp_pins_t);
    localparam hrp_pins_t PINS_IDLE = '{sel_n: 1'b1, rnw: 1'b0, strb: 1'b0, bsel: 1'b0};

    typedef struct packed {
        logic cs;       // chip selected
        logic strb_on;  // strobe at active level
        logic read;     // read direction
        logic hi;       // high byte selected
    } hrp_req_t;

    function automatic hrp_req_t hrp_decode(hrp_pins_t p, hrp_ctl_t c);
        hrp_req_t r;
        r.cs      = ~p.sel_n;
        r.strb_on = (p.strb == c.inv_strb);
        r.read    = p.rnw;
        r.hi      = p.bsel ^ c.inv_bsel;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] hrp_pick(logic [WORD_W-1:0] w, logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/hrp_ctl_reg.sv
module hrp_ctl_reg
    import hrp_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CTL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTL_W-1:0]  wdata,
    output hrp_ctl_t          ctl
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTL_ADDR);

    logic hit;
    assign hit = wr && (addr == SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (hit) begin
            ctl <= hrp_ctl_t'(wdata);
        end
    end

    // R11: other addresses do not disturb the polarity bits
    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == SEL) |=> $stable(ctl));

endmodule

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hrp_bus_drv.sv
module hrp_bus_drv
    import hrp_pkg::*;
(
    input  hrp_pins_t          pins,
    input  hrp_ctl_t           ctl,
    input  logic [WORD_W-1:0]  word,
    output logic [BYTE_W-1:0]  dout,
    output logic               oe
);
    hrp_req_t req;

    always_comb begin
        req  = hrp_decode(pins, ctl);
        oe   = req.cs && req.strb_on && req.read;
        dout = hrp_pick(word, req.hi);
    end

endmodule

// File: rtl/hrp_word_state.sv
module hrp_word_state
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hrp_req_t          req,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q,
    output logic              empty,
    output logic              irq
);
    logic strb_on_d;
    logic pend;
    logic fall;
    logic take;

    assign fall = strb_on_d && !req.strb_on;
    assign take = req.cs && req.strb_on && req.read && req.hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_on_d <= 1'b0;
            pend      <= 1'b0;
            empty     <= 1'b1;
            irq       <= 1'b0;
            word_q    <= '0;
        end else begin
            strb_on_d <= req.strb_on;
            irq       <= 1'b0;
            if (fall)      pend <= 1'b0;
            else if (take) pend <= 1'b1;
            if (word_wr) begin
                word_q <= word_in;
                empty  <= 1'b0;
            end else if (fall && pend && !empty) begin
                empty <= 1'b1;
                irq   <= 1'b1;
            end
        end
    end

    // R7: interrupt is a single-cycle pulse that coincides with the flag rising
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $rose(empty));
    // R9: no new interrupt while already empty
    p_no_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        (empty && $past(empty)) |-> !irq);
    // R10: a load always leaves the buffer full
    p_wr_clears_r10: assert property (@(posedge clk) disable iff (rst)
        word_wr |=> !empty);

endmodule

// File: rtl/hrp_top.sv
module hrp_top
    import hrp_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int CTL_ADDR    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_data,
    input  logic              hst_sel_n,
    input  logic              hst_rnw,
    input  logic              hst_strb,
    input  logic              hst_bsel,
    output logic [BYTE_W-1:0] hbus_dout,
    output logic              hbus_oe,
    output logic              obuf_empty,
    output logic              obuf_irq
);
    hrp_ctl_t          ctl;
    hrp_pins_t         pins_raw;
    hrp_pins_t         pins_s;
    logic [PINS_W-1:0] pins_s_bits;
    hrp_req_t          req_s;
    logic [WORD_W-1:0] word_q;

    assign pins_raw = '{sel_n: hst_sel_n, rnw: hst_rnw, strb: hst_strb, bsel: hst_bsel};

    hrp_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .addr  (ctl_addr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    hrp_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s_bits)
    );

    assign pins_s = hrp_pins_t'(pins_s_bits);
    assign req_s  = hrp_decode(pins_s, ctl);

    hrp_word_state u_state (
        .clk     (clk),
        .rst     (rst),
        .req     (req_s),
        .word_wr (word_wr),
        .word_in (word_data),
        .word_q  (word_q),
        .empty   (obuf_empty),
        .irq     (obuf_irq)
    );

    hrp_bus_drv u_drv (
        .pins (pins_raw),
        .ctl  (ctl),
        .word (word_q),
        .dout (hbus_dout),
        .oe   (hbus_oe)
    );

    // R2/R3: pad stays off whenever chip select is high or direction is write
    p_hiz_desel_r3: assert property (@(posedge clk) disable iff (rst)
        hst_sel_n |-> !hbus_oe);
    p_hiz_write_r2: assert property (@(posedge clk) disable iff (rst)
        !hst_rnw |-> !hbus_oe);

endmodule

// File: tb/test_hrp_top.sv
`timescale 1ns/1ps
module test_hrp_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_wr;
    logic [1:0]  ctl_addr;
    logic [1:0]  ctl_wdata;
    logic        word_wr;
    logic [15:0] word_data;
    logic        hst_sel_n, hst_rnw, hst_strb, hst_bsel;
    logic [7:0]  hbus_dout;
    logic        hbus_oe, obuf_empty, obuf_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    logic inv_s = 1'b0;
    logic inv_b = 1'b0;

    always #4 clk = ~clk;

    hrp_top i_hrp_top (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .word_wr(word_wr), .word_data(word_data),
        .hst_sel_n(hst_sel_n), .hst_rnw(hst_rnw), .hst_strb(hst_strb), .hst_bsel(hst_bsel),
        .hbus_dout(hbus_dout), .hbus_oe(hbus_oe), .obuf_empty(obuf_empty), .obuf_irq(obuf_irq)
    );

    always @(posedge clk) if (!rst && obuf_irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        if (a == 2'd0) begin inv_b = d[0]; inv_s = d[1]; end
        hst_strb = ~inv_s;
        clks(2);
    endtask

    task automatic load_word(input logic [15:0] w);
        @(negedge clk);
        word_wr = 1'b1; word_data = w;
        @(negedge clk);
        word_wr = 1'b0;
        chk(obuf_empty == 1'b0, "R10 load clears empty", obuf_empty, 0);
    endtask

    // host byte read; checks pad behaviour during and after the strobe
    task automatic host_read(input bit hi, input logic [7:0] exp, input string req);
        @(negedge clk);
        hst_sel_n = 1'b0; hst_rnw = 1'b1; hst_bsel = hi ^ inv_b;
        #1;
        chk(hbus_oe == 1'b0, "R2 no drive before strobe", hbus_oe, 0);
        @(negedge clk);
        hst_strb = inv_s;
        #1;
        chk(hbus_oe == 1'b1, "R2 drive during read strobe", hbus_oe, 1);
        chk(hbus_dout == exp, req, hbus_dout, exp);
        @(negedge clk);
        hst_strb = ~inv_s;
        #1;
        chk(hbus_oe == 1'b0, "R3 release on strobe end", hbus_oe, 0);
        @(negedge clk);
        hst_sel_n = 1'b1;
        clks(5);
    endtask

    task automatic t_reset;
        chk(hbus_oe == 1'b0, "R1 oe after reset", hbus_oe, 0);
        chk(obuf_empty == 1'b1, "R1 empty after reset", obuf_empty, 1);
        chk(obuf_irq == 1'b0, "R1 irq after reset", obuf_irq, 0);
        // word is zero: low-byte read shows 00 and, buffer empty, no interrupt
        host_read(1'b0, 8'h00, "R1 word zero after reset");
        host_read(1'b1, 8'h00, "R1 word zero after reset");
        chk(irq_cnt == 0, "R1 no irq from empty buffer", irq_cnt, 0);
    endtask

    task automatic t_word_read;
        int c0;
        load_word(16'hA55A);
        c0 = irq_cnt;
        host_read(1'b0, 8'h5A, "R4 low byte");
        chk(obuf_empty == 1'b0, "R8 low read keeps full", obuf_empty, 0);
        chk(irq_cnt == c0, "R8 low read no irq", irq_cnt, c0);
        host_read(1'b1, 8'hA5, "R4 high byte");
        chk(obuf_empty == 1'b1, "R7 high read empties", obuf_empty, 1);
        chk(irq_cnt == c0 + 1, "R7 one irq pulse", irq_cnt, c0 + 1);
    endtask

    task automatic t_repeat;
        int c0 = irq_cnt;
        host_read(1'b1, 8'hA5, "R9 repeat high byte data");
        chk(obuf_empty == 1'b1, "R9 stays empty", obuf_empty, 1);
        chk(irq_cnt == c0, "R9 no second irq", irq_cnt, c0);
    endtask

    task automatic t_ignored;
        int c0;
        load_word(16'h1234);
        c0 = irq_cnt;
        // write-direction strobe, high byte selected
        @(negedge clk); hst_sel_n = 1'b0; hst_rnw = 1'b0; hst_bsel = 1'b1 ^ inv_b;
        @(negedge clk); hst_strb = inv_s; #1;
        chk(hbus_oe == 1'b0, "R2 no drive on write strobe", hbus_oe, 0);
        @(negedge clk); hst_strb = ~inv_s;
        @(negedge clk); hst_sel_n = 1'b1; hst_rnw = 1'b1;
        clks(5);
        chk(obuf_empty == 1'b0, "R8 write strobe ignored", obuf_empty, 0);
        // strobe without chip select
        @(negedge clk); hst_strb = inv_s; #1;
        chk(hbus_oe == 1'b0, "R2 no drive without select", hbus_oe, 0);
        @(negedge clk); hst_strb = ~inv_s;
        clks(5);
        chk(obuf_empty == 1'b0, "R8 deselected strobe ignored", obuf_empty, 0);
        chk(irq_cnt == c0, "R8 no irq", irq_cnt, c0);
        // chip select released first during a low-byte read
        @(negedge clk); hst_sel_n = 1'b0; hst_bsel = inv_b;
        @(negedge clk); hst_strb = inv_s; #1;
        chk(hbus_dout == 8'h34, "R4 low byte of new word", hbus_dout, 8'h34);
        @(negedge clk); hst_sel_n = 1'b1; #1;
        chk(hbus_oe == 1'b0, "R3 release on select end", hbus_oe, 0);
        @(negedge clk); hst_strb = ~inv_s;
        clks(5);
    endtask

    task automatic t_polarity;
        int c0;
        ctl_write(2'd1, 2'b11);
        host_read(1'b0, 8'h34, "R11 other address ignored");
        ctl_write(2'd0, 2'b01);
        // byte-select line now low means high byte
        chk(inv_b == 1'b1, "R5 setup", inv_b, 1);
        @(negedge clk); hst_sel_n = 1'b0; hst_rnw = 1'b1; hst_bsel = 1'b0;
        @(negedge clk); hst_strb = 1'b0; #1;
        chk(hbus_dout == 8'h12, "R5 inverted select gives high byte", hbus_dout, 8'h12);
        @(negedge clk); hst_strb = 1'b1;
        @(negedge clk); hst_sel_n = 1'b1;
        clks(5);
        load_word(16'hC3E7);
        ctl_write(2'd0, 2'b11);
        @(negedge clk); hst_sel_n = 1'b0; hst_bsel = 1'b1; #1;
        chk(hbus_oe == 1'b0, "R6 low line inactive when inverted", hbus_oe, 0);
        @(negedge clk); hst_strb = 1'b1; #1;
        chk(hbus_oe == 1'b1, "R6 high line active when inverted", hbus_oe, 1);
        chk(hbus_dout == 8'hE7, "R5 line high gives low byte", hbus_dout, 8'hE7);
        @(negedge clk); hst_strb = 1'b0;
        @(negedge clk); hst_sel_n = 1'b1;
        clks(5);
        c0 = irq_cnt;
        host_read(1'b1, 8'hC3, "R6 high byte with both inverted");
        chk(obuf_empty == 1'b1, "R7 empties with inverted strobe", obuf_empty, 1);
        chk(irq_cnt == c0 + 1, "R7 irq with inverted strobe", irq_cnt, c0 + 1);
        ctl_write(2'd0, 2'b00);
    endtask

    task automatic t_collide;
        int c0;
        load_word(16'h0F0F);
        c0 = irq_cnt;
        @(negedge clk); hst_sel_n = 1'b0; hst_rnw = 1'b1; hst_bsel = 1'b1;
        @(negedge clk); hst_strb = 1'b0;
        clks(3);
        hst_strb = 1'b1;           // release; sync stages at next two edges
        clks(2);
        word_wr = 1'b1; word_data = 16'hBEEF;  // lands on the edge that sees the fall
        @(negedge clk);
        word_wr = 1'b0;
        hst_sel_n = 1'b1;
        clks(4);
        chk(obuf_empty == 1'b0, "R10 write wins collision", obuf_empty, 0);
        chk(irq_cnt == c0, "R10 no irq on collision", irq_cnt, c0);
        host_read(1'b0, 8'hEF, "R10 new word loaded");
    endtask

    initial begin
        rst = 1'b1; ctl_wr = 0; ctl_addr = 0; ctl_wdata = 0; word_wr = 0; word_data = 0;
        hst_sel_n = 1'b1; hst_rnw = 1'b1; hst_strb = 1'b1; hst_bsel = 1'b0;
        clks(4);
        rst = 1'b0;
        clks(2);
        t_reset();
        t_word_read();
        t_repeat();
        t_ignored();
        t_polarity();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule